// File: doc/BRIEF.md
# SPI FIFO Pair with Trigger Interrupts

This block buffers bytes between a register port and the shift engine of an SPI controller. It holds one byte-wide transmit FIFO and one byte-wide receive FIFO. Software pushes transmit bytes and pops received bytes through the register port. The shift engine pops transmit bytes from the head of the transmit FIFO and pushes received bytes into the receive FIFO.

The block reports both fill counts in one status word. It compares each count against its own programmable trigger level. It keeps a sticky status register that software clears by writing 1 to a bit, and an enable register with the same bit layout. A single interrupt line goes high whenever a pending status bit is also enabled. A control bit empties each FIFO; the bit reads back as 1 for one cycle and then clears itself.

Register word addresses (`reg_addr`):

| Address | Register |
|---|---|
| 0 | interrupt enable |
| 1 | interrupt status |
| 2 | FIFO control |
| 3 | FIFO status |
| 4 | transmit data push (write only; reads return 0) |
| 5 | receive data pop (read only) |

Top module: `spi_fifo_pair`

## Requirements
- R1: FIFO depth is the parameter `DEPTH` (default 64). The count field width is CW = clog2(DEPTH+1). Reading address 3 returns the receive count in bits [CW-1:0] and the transmit count in bits [16+CW-1:16]; all other bits read 0.
- R2: A write to address 4 pushes `reg_wdata[7:0]` into the transmit FIFO. `tx_byte` always shows the oldest byte, and a `tx_pop` pulse removes it, so bytes leave in push order. A push into a full transmit FIFO is dropped. A `tx_pop` while the FIFO is empty (`tx_empty`=1) has no effect.
- R3: A `rx_push` pulse stores `rx_byte`. A read of address 5 returns the oldest byte in bits [7:0] and removes it, so bytes leave in push order. A read of an empty receive FIFO returns 0 and leaves the count at 0.
- R4: A `rx_push` into a full receive FIFO, with no pop in the same cycle, drops the byte and sets status bit 8 (overflow). A push and a pop in the same cycle on a full FIFO both take effect: the count stays at DEPTH and no overflow is flagged.
- R5: Status bit 0 (receive ready) is set in every cycle after one in which the receive count is at or above the level in control bits [7:0].
- R6: Status bit 4 (transmit request) is set in every cycle after one in which the transmit count is at or below the level in control bits [23:16].
- R7: A `xfer_done` pulse sets status bit 12 (transfer complete) on the next cycle.
- R8: Writing 1 to a status bit clears it. Writing 0 to a bit has no effect. If the bit's set condition holds in the same cycle as the clear, the bit stays set. Writing all ones clears every bit whose condition is false.
- R9: A control write with bit 15 set empties the receive FIFO. A control write with bit 31 set empties the transmit FIFO. The same write also loads both levels. The written reset bit reads back as 1 in the following cycle and as 0 after that.
- R10: Address 0 holds the enable bits at positions 0, 4, 8 and 12; all other bits read 0. `irq` is high exactly when some status bit and its enable bit are both 1.
- R11: After reset both counts are 0, the enable register is 0, the receive level is 1, the transmit level is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops when reading address 5) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| rx_push | input | 1 | Shift engine stores a received byte |
| rx_byte | input | 8 | Received byte |
| tx_pop | input | 1 | Shift engine consumes the head transmit byte |
| tx_byte | output | 8 | Head of the transmit FIFO |
| tx_empty | output | 1 | Transmit FIFO holds no byte |
| xfer_done | input | 1 | Transfer-complete pulse from the shift engine |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land in the same cycle. The first pair is a receive push from the shift engine and a register pop of the same FIFO while it is full. The bench fills the FIFO to DEPTH, clears the overflow flag, and then drives `rx_push` and a read of address 5 in one cycle. It judges the result by three things: the count stays at DEPTH, status bit 8 stays clear, and the draining order ends with the pushed byte. The second pair is a status clear written while that bit's level condition still holds; the bench expects the bit to read back as set.

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair #(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        rx_push,
  input  logic [7:0]  rx_byte,
  input  logic        tx_pop,
  output logic [7:0]  tx_byte,
  output logic        tx_empty,
  input  logic        xfer_done,
  output logic        irq
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  localparam logic [2:0] A_EN   = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_CTRL = 3'd2;
  localparam logic [2:0] A_CNT  = 3'd3;
  localparam logic [2:0] A_TXD  = 3'd4;
  localparam logic [2:0] A_RXD  = 3'd5;

  logic [7:0]    rx_mem [DEPTH];
  logic [7:0]    tx_mem [DEPTH];
  logic [PW-1:0] rx_wp, rx_rp, tx_wp, tx_rp;
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic [7:0]    rx_lvl, tx_lvl;
  logic          rx_rst_q, tx_rst_q;
  logic [3:0]    stat_q, en_q;

  wire wr_en   = reg_wr && reg_addr == A_EN;
  wire wr_stat = reg_wr && reg_addr == A_STAT;
  wire wr_ctrl = reg_wr && reg_addr == A_CTRL;
  wire wr_txd  = reg_wr && reg_addr == A_TXD;

  wire rx_rst_req = wr_ctrl && reg_wdata[15];
  wire tx_rst_req = wr_ctrl && reg_wdata[31];

  wire rx_out = reg_rd && reg_addr == A_RXD && rx_cnt != '0;
  wire rx_in  = rx_push && (rx_cnt != FULL || rx_out);
  wire rx_ovf = rx_push && rx_cnt == FULL && !rx_out && !rx_rst_req;
  wire tx_in  = wr_txd && tx_cnt != FULL;
  wire tx_out = tx_pop && tx_cnt != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rx_rst_req) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_in)  rx_wp <= (rx_wp == LAST) ? '0 : rx_wp + 1'b1;
      if (rx_out) rx_rp <= (rx_rp == LAST) ? '0 : rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_in) - CW'(rx_out);
    end
  end

  always_ff @(posedge clk)
    if (rx_in && !rx_rst_req) rx_mem[rx_wp] <= rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (tx_rst_req) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_in)  tx_wp <= (tx_wp == LAST) ? '0 : tx_wp + 1'b1;
      if (tx_out) tx_rp <= (tx_rp == LAST) ? '0 : tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_in) - CW'(tx_out);
    end
  end

  always_ff @(posedge clk)
    if (tx_in && !tx_rst_req) tx_mem[tx_wp] <= reg_wdata[7:0];

  wire       rx_ready = 9'(rx_cnt) >= 9'(rx_lvl);
  wire       tx_req   = 9'(tx_cnt) <= 9'(tx_lvl);
  wire [3:0] set_v    = {xfer_done, rx_ovf, tx_req, rx_ready};
  wire [3:0] clr_v    = wr_stat ? {reg_wdata[12], reg_wdata[8], reg_wdata[4], reg_wdata[0]} : 4'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q   <= '0;
      en_q     <= '0;
      rx_lvl   <= 8'd1;
      tx_lvl   <= 8'd0;
      rx_rst_q <= 1'b0;
      tx_rst_q <= 1'b0;
    end else begin
      stat_q   <= (stat_q & ~clr_v) | set_v;
      rx_rst_q <= rx_rst_req;
      tx_rst_q <= tx_rst_req;
      if (wr_en) en_q <= {reg_wdata[12], reg_wdata[8], reg_wdata[4], reg_wdata[0]};
      if (wr_ctrl) begin
        rx_lvl <= reg_wdata[7:0];
        tx_lvl <= reg_wdata[23:16];
      end
    end
  end

  function automatic logic [31:0] spread(input logic [3:0] b);
    return {19'b0, b[3], 3'b0, b[2], 3'b0, b[1], 3'b0, b[0]};
  endfunction

  assign irq      = |(stat_q & en_q);
  assign tx_byte  = tx_mem[tx_rp];
  assign tx_empty = tx_cnt == '0;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_EN:   reg_rdata = spread(en_q);
      A_STAT: reg_rdata = spread(stat_q);
      A_CTRL: reg_rdata = {tx_rst_q, 7'b0, tx_lvl, rx_rst_q, 7'b0, rx_lvl};
      A_CNT: begin
        reg_rdata[CW-1:0]     = rx_cnt;
        reg_rdata[16+CW-1:16] = tx_cnt;
      end
      A_RXD:  reg_rdata = (rx_cnt != '0) ? {24'b0, rx_mem[rx_rp]} : 32'b0;
      default: reg_rdata = '0;
    endcase
  end

  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) rx_cnt <= FULL && tx_cnt <= FULL); // R1
  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_cnt == FULL && !(reg_rd && reg_addr == A_RXD) && !(wr_ctrl && reg_wdata[15])) |=> stat_q[2]); // R4
  AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_cnt == FULL && reg_rd && reg_addr == A_RXD && !wr_ctrl) |=> rx_cnt == FULL); // R4
  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n) xfer_done |=> stat_q[3]); // R7
  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_STAT && reg_wdata[12] && !xfer_done) |=> !stat_q[3]); // R8
  AST_RST_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n) (rx_rst_q || tx_rst_q) |=> !(rx_rst_q && $past(!rx_rst_req)) && !(tx_rst_q && $past(!tx_rst_req))); // R9
  AST_RST_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (wr_ctrl && reg_wdata[15]) |=> rx_cnt == '0); // R9

endmodule

// File: tb/spi_fifo_pair_tb.sv
`timescale 1ns/1ps
module spi_fifo_pair_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rx_push = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        tx_pop = 1'b0;
  logic [7:0]  tx_byte;
  logic        tx_empty;
  logic        xfer_done = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  spi_fifo_pair #(.DEPTH(64)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_push(rx_push), .rx_byte(rx_byte),
    .tx_pop(tx_pop), .tx_byte(tx_byte), .tx_empty(tx_empty), .xfer_done(xfer_done), .irq(irq)
  );

  // {kind (1 = read and compare, 0 = write), addr, data}
  localparam int NV = 12;
  localparam logic [35:0] VEC [NV] = '{
    {1'b1, 3'd3, 32'h0000_0000},  // R11 R1 counts zero
    {1'b1, 3'd2, 32'h0000_0001},  // R11 levels
    {1'b1, 3'd0, 32'h0000_0000},  // R11 enables
    {1'b1, 3'd1, 32'h0000_0010},  // R6 tx count 0 <= level 0
    {1'b0, 3'd4, 32'h0000_00A1},
    {1'b0, 3'd4, 32'h0000_00B2},
    {1'b0, 3'd4, 32'h0000_00C3},
    {1'b1, 3'd3, 32'h0003_0000},  // R1 R2 tx count 3
    {1'b0, 3'd2, 32'h0002_0004},
    {1'b1, 3'd2, 32'h0002_0004},  // R9 levels loaded
    {1'b0, 3'd1, 32'h0000_0010},
    {1'b1, 3'd1, 32'h0000_0000}   // R8 R6 cleared, 3 > 2
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic read_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] d;
    reg_read(a, d);
    chk(tag, d, exp);
  endtask

  task automatic push_rx(input logic [7:0] b);
    rx_push = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic pop_tx();
    tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    idle(2);
    rst_n = 1'b1;
    idle(2);
    chk("R11 irq after reset", {31'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][35]) read_chk("R1 R6 R8 R11 vector", VEC[i][34:32], VEC[i][31:0]);
      else reg_write(VEC[i][34:32], VEC[i][31:0]);
    end

    // R2 head order and pop
    chk("R2 head", {24'b0, tx_byte}, 32'hA1);
    pop_tx();
    chk("R2 next head", {24'b0, tx_byte}, 32'hB2);
    idle(2);
    read_chk("R6 tx request at level", 3'd1, 32'h10);

    // R5 receive ready
    push_rx(8'h11); push_rx(8'h22); push_rx(8'h33);
    idle(2);
    read_chk("R5 below level", 3'd1, 32'h10);
    push_rx(8'h44);
    idle(2);
    read_chk("R5 at level", 3'd1, 32'h11);
    read_chk("R1 counts", 3'd3, 32'h0002_0004);

    // R3 pop order
    read_chk("R3 pop first", 3'd5, 32'h11);
    read_chk("R3 pop second", 3'd5, 32'h22);

    // R8 clear semantics
    reg_write(3'd1, 32'h1);
    read_chk("R8 clear bit0", 3'd1, 32'h10);
    reg_write(3'd1, 32'h0);
    read_chk("R8 zero write", 3'd1, 32'h10);
    reg_write(3'd1, 32'h10);
    read_chk("R8 condition wins", 3'd1, 32'h10);

    // R7 transfer complete
    xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
    read_chk("R7 done bit", 3'd1, 32'h1010);

    // R10 enables and irq
    chk("R10 irq disabled", {31'b0, irq}, 32'h0);
    reg_write(3'd0, 32'hFFFF_FFFF);
    read_chk("R10 enable readback", 3'd0, 32'h1111);
    chk("R10 irq all enabled", {31'b0, irq}, 32'h1);
    reg_write(3'd0, 32'h1);
    chk("R10 irq unmatched enable", {31'b0, irq}, 32'h0);
    reg_write(3'd0, 32'h1000);
    chk("R10 irq done enabled", {31'b0, irq}, 32'h1);
    reg_write(3'd1, 32'hFFFF_FFFF);
    chk("R10 irq after clear all", {31'b0, irq}, 32'h0);
    read_chk("R8 clear all", 3'd1, 32'h10);
    reg_write(3'd0, 32'h0);

    // R9 receive reset bit
    reg_write(3'd2, 32'h0002_8004);
    read_chk("R9 rx reset visible", 3'd2, 32'h0002_8004);
    read_chk("R9 rx reset self clears", 3'd2, 32'h0002_0004);
    read_chk("R9 rx emptied", 3'd3, 32'h0002_0000);

    // R4 overflow and collision
    for (int i = 0; i < 64; i++) push_rx(8'(i));
    push_rx(8'hEE);
    idle(2);
    read_chk("R4 count at full", 3'd3, 32'h0002_0040);
    read_chk("R4 overflow flagged", 3'd1, 32'h111);
    reg_write(3'd1, 32'h100);
    read_chk("R4 overflow cleared", 3'd1, 32'h011);
    rx_push = 1'b1; rx_byte = 8'hF0;
    reg_rd = 1'b1; reg_addr = 3'd5;
    #1 d = reg_rdata;
    @(negedge clk);
    rx_push = 1'b0; reg_rd = 1'b0;
    chk("R4 collision pop value", d, 32'h0);
    idle(2);
    read_chk("R4 collision no overflow", 3'd1, 32'h011);
    read_chk("R4 collision count", 3'd3, 32'h0002_0040);
    for (int i = 1; i < 64; i++) read_chk("R3 R4 drain order", 3'd5, 32'(i));
    read_chk("R4 pushed byte last", 3'd5, 32'hF0);
    read_chk("R3 empty read", 3'd5, 32'h0);
    read_chk("R3 empty count", 3'd3, 32'h0002_0000);

    // R9 transmit reset, R2 full and empty
    reg_write(3'd2, 32'h8002_0004);
    read_chk("R9 tx reset visible", 3'd2, 32'h8002_0004);
    read_chk("R9 tx emptied", 3'd3, 32'h0);
    for (int i = 0; i < 65; i++) reg_write(3'd4, 32'h80 + 32'(i));
    read_chk("R2 full count", 3'd3, 32'h0040_0000);
    for (int i = 0; i < 64; i++) begin
      chk("R2 tx order", {24'b0, tx_byte}, 32'h80 + 32'(i));
      pop_tx();
    end
    chk("R2 empty flag", {31'b0, tx_empty}, 32'h1);
    pop_tx();
    read_chk("R2 pop on empty ignored", 3'd3, 32'h0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule